// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

The block watches one tearing-effect line driven by a display panel. Both horizontal and vertical sync pulses share this single pin. The block tells the two apart by how long each pulse lasts, counted in clock ticks. Software programs a horizontal width threshold, a vertical width threshold and a polarity for each kind of pulse.

From these pulses the block makes a single active-low match strobe, one tick wide, which a falling-edge interrupt or a transfer starter can use. There are two ways to make a match. In vertical-only mode every vertical sync produces a match. In line mode the block counts horizontal syncs after a vertical sync and produces a match when the count reaches a programmed line.

Configuration is written through a plain write port that selects one of two words. The timing word holds the thresholds, the target line, the mode and the polarities. The control word holds the enable.

Top module: `te_sync_detect`

## Requirements
- R1: After reset, `match_n` is 1, both configuration words read as zero, and detection is disabled.
- R2: Writing with `cfg_sel`=1 sets the enable from `cfg_wdata[6]`. While the enable is 0, `match_n` stays 1 and the line state is cleared, so a vertical sync seen before a disable does not count after the block is enabled again.
- R3: A pulse is a stretch of ticks during which the input is at its active level. The active level is high, but `cfg_wdata[29]` of the timing word (`cfg_sel`=0) inverts it for horizontal measurement and `cfg_wdata[28]` inverts it for vertical measurement.
- R4: The vertical threshold is (V+1)*8 ticks, where V is timing bits 14:3. A pulse whose width is at least this threshold is a vertical sync.
- R5: The horizontal threshold is H+1 ticks, where H is timing bits 2:0. A pulse whose width is at least H+1 and below the vertical threshold is a horizontal sync. A pulse shorter than H+1 ticks is ignored.
- R6: The mode is timing bits 27:26. When the mode is 3, each vertical sync produces one match.
- R7: In mode 2, a vertical sync clears the line count to 0. Each later horizontal sync adds one to the count, and the count saturates at 2047. A match is produced when an increment makes the count equal to the target line in timing bits 25:15. Horizontal syncs that arrive before the first vertical sync since the block was enabled are not counted.
- R8: In modes 0 and 1, no match is ever produced.
- R9: Each match drives `match_n` low for exactly one tick.
- R10: The input passes through `SYNC_STAGES` flops before it is measured. This delay does not change the width that is measured, so a pulse exactly at a threshold is classified as having reached it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_in | input | 1 | Tearing-effect pin from the panel (asynchronous) |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_sel | input | 1 | Word select: 0 selects the timing word, 1 selects the control word |
| cfg_wdata | input | 32 | Write data |
| match_n | output | 1 | Active-low match strobe, one tick wide |

## Verification
The only way to observe the block's state is through `match_n`, so every error in that state shows up as a missing match, an extra match or a match on the wrong pulse. A width counter that is off by one only shows when a pulse lies exactly on a threshold. For that reason the directed pulses sit at H, H+1, 8(V+1)-1 and 8(V+1) ticks. A line counter that was not cleared properly shows on the next horizontal sync that reaches the target line, within a few ticks of the end of that pulse. Random pulse trains are then compared with a bench model that counts the expected matches for each configuration.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
   localparam int HCODE_W = 3;
   localparam int VCODE_W = 12;
   localparam int LINE_W  = 11;

   typedef enum logic [1:0] {
      TE_OFF   = 2'd0,
      TE_RSVD  = 2'd1,
      TE_LINE  = 2'd2,
      TE_VONLY = 2'd3
   } te_mode_e;

   typedef struct packed {
      logic              h_inv;
      logic              v_inv;
      te_mode_e          mode;
      logic [LINE_W-1:0] line;
      logic [VCODE_W-1:0] v_code;
      logic [HCODE_W-1:0] h_code;
   } te_cfg_t;
endpackage

// File: rtl/te_cfg_regs.sv
module te_cfg_regs
   import te_sync_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic        cfg_sel,
   input  logic [31:0] cfg_wdata,
   output te_cfg_t     cfg,
   output logic        enable
);
   logic unused_bits;
   assign unused_bits = ^cfg_wdata[31:30];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= '0;
         enable <= 1'b0;
      end else if (cfg_we) begin
         if (cfg_sel) begin
            enable <= cfg_wdata[6];
         end else begin
            cfg.h_code <= cfg_wdata[2:0];
            cfg.v_code <= cfg_wdata[14:3];
            cfg.line   <= cfg_wdata[25:15];
            cfg.mode   <= te_mode_e'(cfg_wdata[27:26]);
            cfg.v_inv  <= cfg_wdata[28];
            cfg.h_inv  <= cfg_wdata[29];
         end
      end
   end

   // R2
   enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel) |=> (enable == $past(cfg_wdata[6])));
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
   parameter int WIDTH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               active,
   output logic               end_stb,
   output logic [WIDTH_W-1:0] end_width
);
   localparam logic [WIDTH_W-1:0] CNT_MAX = '1;

   logic               prev;
   logic [WIDTH_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev      <= 1'b0;
         cnt       <= '0;
         end_stb   <= 1'b0;
         end_width <= '0;
      end else if (clr) begin
         prev      <= 1'b0;
         cnt       <= '0;
         end_stb   <= 1'b0;
         end_width <= '0;
      end else begin
         prev    <= active;
         end_stb <= prev && !active;
         if (prev && !active) end_width <= cnt;
         if (active) cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
         else        cnt <= '0;
      end
   end

   // R10
   width_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_stb |-> (end_width != '0));
   // R3
   end_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      end_stb |=> !end_stb);
endmodule

// File: rtl/te_line_matcher.sv
module te_line_matcher
   import te_sync_pkg::*;
#(
   parameter int WIDTH_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  te_mode_e           mode,
   input  logic [LINE_W-1:0]  target,
   input  logic [HCODE_W-1:0] h_code,
   input  logic [VCODE_W-1:0] v_code,
   input  logic               h_end,
   input  logic [WIDTH_W-1:0] h_width,
   input  logic               v_end,
   input  logic [WIDTH_W-1:0] v_width,
   output logic               match_n
);
   localparam logic [LINE_W-1:0] LINE_MAX = '1;

   logic [WIDTH_W-1:0] h_thr, v_thr;
   logic               v_evt, h_evt;
   logic [LINE_W-1:0]  line_cnt, line_nxt;
   logic               vs_seen;

   always_comb begin
      h_thr    = WIDTH_W'(h_code) + WIDTH_W'(1);
      v_thr    = (WIDTH_W'(v_code) + WIDTH_W'(1)) << 3;
      v_evt    = v_end && (v_width >= v_thr);
      h_evt    = h_end && (h_width >= h_thr) && (h_width < v_thr);
      line_nxt = (line_cnt == LINE_MAX) ? line_cnt : line_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
         vs_seen  <= 1'b0;
         match_n  <= 1'b1;
      end else if (clr) begin
         line_cnt <= '0;
         vs_seen  <= 1'b0;
         match_n  <= 1'b1;
      end else begin
         match_n <= 1'b1;
         if (v_evt) begin
            line_cnt <= '0;
            vs_seen  <= 1'b1;
            if (mode == TE_VONLY) match_n <= 1'b0;
         end else if (h_evt && vs_seen) begin
            line_cnt <= line_nxt;
            if (mode == TE_LINE && line_nxt == target) match_n <= 1'b0;
         end
      end
   end

   // R9
   match_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match_n |=> match_n);
   // R6
   vonly_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && v_evt && mode == TE_VONLY) |=> !match_n);
   // R8
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TE_OFF || mode == TE_RSVD) |=> match_n);
   // R7
   vsync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && v_evt) |=> (line_cnt == '0));
endmodule

// File: rtl/te_sync_detect.sv
module te_sync_detect
   import te_sync_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WIDTH_W     = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        te_in,
   input  logic        cfg_we,
   input  logic        cfg_sel,
   input  logic [31:0] cfg_wdata,
   output logic        match_n
);
   localparam int MIN_WIDTH_W = VCODE_W + 4;
   localparam int N_CH        = 2;

   generate
      if (WIDTH_W < MIN_WIDTH_W) begin : g_bad_width
         $error("WIDTH_W too small for the largest vertical threshold");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   te_cfg_t cfg;
   logic    enable;
   logic    te_sync;

   te_cfg_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg       (cfg),
      .enable    (enable)
   );

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign te_sync = te_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stage;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage <= '0;
            else        stage <= {stage[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], te_in};
         end
         assign te_sync = stage[SYNC_STAGES-1];
      end
   endgenerate

   // channel 0 measures horizontal pulses, channel 1 vertical ones
   logic [N_CH-1:0]         ch_inv;
   logic [N_CH-1:0]         ch_end;
   logic [WIDTH_W-1:0]      ch_width [N_CH];

   assign ch_inv = {cfg.v_inv, cfg.h_inv};

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         te_pulse_meter #(.WIDTH_W(WIDTH_W)) u_meter (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (!enable),
            .active    (te_sync ^ ch_inv[c]),
            .end_stb   (ch_end[c]),
            .end_width (ch_width[c])
         );
      end
   endgenerate

   te_line_matcher #(.WIDTH_W(WIDTH_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!enable),
      .mode    (cfg.mode),
      .target  (cfg.line),
      .h_code  (cfg.h_code),
      .v_code  (cfg.v_code),
      .h_end   (ch_end[0]),
      .h_width (ch_width[0]),
      .v_end   (ch_end[1]),
      .v_width (ch_width[1]),
      .match_n (match_n)
   );

   // R2
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> match_n);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (match_n && !enable));
endmodule

// File: tb/te_sync_detect_test.sv
module te_sync_detect_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        te_in = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        match_n;

   int errors = 0;
   int checks = 0;
   int match_cnt = 0;
   int low_run = 0;
   int max_run = 0;
   bit done = 0;

   // bench model of the programmed configuration
   int  m_mode, m_ht, m_vt, m_target, m_line;
   bit  m_en, m_vs, m_idle;
   int  exp_cnt, base_cnt;

   always #5 clk = ~clk;

   te_sync_detect uut (
      .clk(clk), .rst_n(rst_n), .te_in(te_in), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .match_n(match_n)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (!match_n) begin
            match_cnt++;
            low_run++;
            if (low_run > max_run) max_run = low_run;
         end else low_run = 0;
      end
   end

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wr(input bit sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_enable(input bit en);
      wr(1'b1, en ? 32'h40 : 32'h0);
      m_en = en; m_vs = 0; m_line = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic configure(input int mode, input int hf, input int vf,
                            input int target, input bit inv);
      logic [31:0] w;
      set_enable(0);
      w = 32'(hf) | (32'(vf) << 3) | (32'(target) << 15) | (32'(mode) << 26)
          | (32'(inv) << 28) | (32'(inv) << 29);
      wr(1'b0, w);
      te_in = inv;
      m_idle = inv; m_mode = mode; m_ht = hf + 1; m_vt = (vf + 1) * 8;
      m_target = target;
      repeat (6) @(negedge clk);
      set_enable(1);
   endtask

   function automatic int model_pulse(input int w);
      int inc = 0;
      if (!m_en) return 0;
      if (w >= m_vt) begin
         m_line = 0; m_vs = 1;
         if (m_mode == 3) inc = 1;
      end else if (w >= m_ht && m_vs) begin
         if (m_line < 2047) m_line++;
         if (m_mode == 2 && m_line == m_target) inc = 1;
      end
      return inc;
   endfunction

   task automatic pulse(input int w);
      @(negedge clk);
      te_in = ~m_idle;
      repeat (w) @(negedge clk);
      te_in = m_idle;
      repeat (6) @(negedge clk);
      exp_cnt += model_pulse(w);
   endtask

   task automatic begin_scn();
      repeat (2) @(negedge clk);
      base_cnt = match_cnt; exp_cnt = 0;
   endtask

   task automatic end_scn(input string req);
      repeat (8) @(negedge clk);
      check(req, match_cnt - base_cnt, exp_cnt);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_7e01));
      m_en = 0; m_vs = 0; m_line = 0; m_idle = 0;
      m_mode = 0; m_ht = 1; m_vt = 8; m_target = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 match_n after reset", int'(match_n), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 match_n idle", int'(match_n), 1);

      // R2: disabled block ignores vertical syncs
      configure(3, 2, 0, 0, 0);
      set_enable(0);
      begin_scn();
      pulse(12); pulse(20);
      end_scn("R2 disabled no match");

      // R4 R5 R10: threshold boundaries in vertical-only mode (ht=3, vt=8)
      configure(3, 2, 0, 0, 0);
      begin_scn();
      pulse(7); pulse(8); pulse(2); pulse(20);
      end_scn("R4 R10 vertical boundary, R6 vonly");

      // R7 R5: line mode, target 3, ht=3, vt=16
      configure(2, 2, 1, 3, 0);
      begin_scn();
      pulse(5); pulse(5);              // before first vsync: not counted
      pulse(16);                       // vsync
      pulse(2);                        // glitch, ignored
      pulse(3); pulse(15); pulse(5);   // lines 1..3 -> match
      pulse(5);                        // line 4, no match
      end_scn("R7 R5 line match at target");

      // R7: vsync restarts the count
      begin_scn();
      pulse(20); pulse(3); pulse(3); pulse(3);
      end_scn("R7 count restarts after vsync");

      // R2: disable clears the seen-vsync state
      configure(2, 0, 0, 1, 0);
      pulse(8);
      set_enable(0);
      set_enable(1);
      begin_scn();
      pulse(3);
      end_scn("R2 state cleared by disable");

      // R8: modes 0 and 1 never match
      configure(0, 0, 0, 1, 0);
      begin_scn();
      pulse(9); pulse(2); pulse(9);
      end_scn("R8 mode 0 silent");
      configure(1, 0, 0, 1, 0);
      begin_scn();
      pulse(9); pulse(2); pulse(9);
      end_scn("R8 mode 1 silent");

      // R3: inverted polarity, idle level high
      configure(3, 1, 0, 0, 1);
      begin_scn();
      pulse(8); pulse(4); pulse(30);
      end_scn("R3 inverted polarity");

      // random rounds
      for (int r = 0; r < 4; r++) begin
         int mode, hf, vf, tgt;
         mode = ($urandom % 2) ? 3 : 2;
         hf   = $urandom % 8;
         vf   = 1 + ($urandom % 3);
         tgt  = 1 + ($urandom % 4);
         configure(mode, hf, vf, tgt, bit'($urandom % 2));
         begin_scn();
         for (int p = 0; p < 25; p++) begin
            pulse(1 + int'($urandom % (m_vt + 5)));
         end
         end_scn(mode == 3 ? "R6 random vonly" : "R7 random line");
      end

      // R9: every match is one tick wide
      check("R9 match width", max_run, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule